// File: doc/BRIEF.md
# Serial Fifth-Order Sigma-Delta Noise Shaper

This block turns an oversampled signed PCM stream into a nine-level code for an eight-slot pulse-width output stage of an audio DAC. The loop filter has five integrators in a cascade with feedback from the quantizer. Two local resonator paths subtract an arithmetically shifted copy of the following stage's output, which places the notches of the noise transfer function. Every integrator is saturated at a power-of-two limit, so the loop recovers after an input overload. A xorshift128+ generator adds dither in front of the quantizer.

The five integrator states are not kept in five separate registers. They circulate through a five-entry shift ring, and one shared adder and one clamp work on one stage per processing clock. The processing clock therefore runs at five times the modulator rate. A group of five cycles accepts one input sample and produces one output code. The sample rate upstream must be an integer fraction of one eighth of the modulator rate. Interpolation, the serial audio input and the analogue output stage are outside this block.

Top module: `sdm_serial_shaper`

## Requirements
- R1: While the synchronized reset is high, all five integrator states are zero, `out_level` is 4, `out_pattern` is 8'h0F and `out_valid` is 0. The dither state is reloaded with its two non-zero seeds.
- R2: After reset, the processing cycles form groups of five, phases 0 to 4. `in_take` is high exactly in the phase-0 cycle, and `in_sample` is captured at the clock edge that ends that cycle. `out_valid` is high for one cycle, in the phase-0 cycle of the following group, and then stays low for four cycles.
- R3: For each sample x, with F = (L - 4) * 2^FB_SH and L the current level, the stages update in order 0 to 4. Stage 0 becomes s0 + x - F. Each later stage k becomes sk + (the freshly updated stage k-1) - F, minus its resonator term where one exists.
- R4: Stage 1 also subtracts the old stage-2 value shifted right arithmetically by RES1_SH. Stage 3 also subtracts the old stage-4 value shifted by RES2_SH.
- R5: Each stage result is saturated to the range [-2^CLAMP_SH, 2^CLAMP_SH - 1].
- R6: The new level is L = clamp(((s4 + d + 2^(FB_SH-1)) >>> FB_SH) + 4, 0, 8), where s4 is the new stage-4 value. `out_pattern` bit i is 1 exactly when i < L (thermometer code, slot 0 first).
- R7: The dither d is the top DITH_W bits, read as signed, of the 64-bit sum of the two generator words a and b. It is read before the generator steps. The generator steps once per group: t = a ^ (a << 23), a' = b, b' = t ^ b ^ (t >> 18) ^ (b >> 5), with logical shifts.
- R8: `rst` passes through a two-flop synchronizer. After `rst` falls, `in_take` rises at the second rising clock edge.
- R9: `out_level` and `out_pattern` change only at the edge that raises `out_valid`. Between valid strobes they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, five times the modulator rate |
| rst | input | 1 | Active-high reset, asynchronous to the block and synchronized inside |
| in_sample | input | IN_W | Signed oversampled PCM sample |
| in_take | output | 1 | High in the cycle whose closing edge captures `in_sample` |
| out_valid | output | 1 | One-cycle strobe marking a new output code |
| out_level | output | 4 | Quantizer level, 0 to 8 active slots |
| out_pattern | output | 8 | Thermometer slot pattern for the pulse-width stage |

## Verification
The hardest condition to reach from the ports is integrator saturation. With an input within range the loop stays far from the clamp limits, and the resonator terms on stages 1 and 3 only matter once the states have grown. The stimulus therefore drives long runs of positive and negative full-scale samples, which overload the loop, and then an alternating near-full-scale sequence. It also applies a reset in the middle of the overload, so that recovery from clamped states is checked as well. Each code is compared against an unserialized behavioural model in which dither runs at all times.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int NSTG    = 5;   // integrator stages, also ring length
  localparam int LVL_W   = 4;   // level code width
  localparam int SLOTS   = 8;   // pulse-width slots
  localparam int MID_LVL = 4;   // level whose feedback is zero
  localparam int MAX_LVL = 8;
  localparam int PH_W    = $clog2(NSTG);
endpackage

// File: rtl/sdm_acc_ring.sv
module sdm_acc_ring
  import sdm_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int ACC_W    = 22,
  parameter int FB_SH    = 13,
  parameter int CLAMP_SH = 19,
  parameter int RES1_SH  = 6,
  parameter int RES2_SH  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         phase,
  input  logic signed [IN_W-1:0]  x_in,
  input  logic [LVL_W-1:0]        lvl,
  output logic signed [ACC_W-1:0] acc_new
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] LIM_HI =
    {{(SUM_W-CLAMP_SH){1'b0}}, {CLAMP_SH{1'b1}}};
  localparam logic signed [SUM_W-1:0] LIM_LO = ~LIM_HI;

  logic signed [ACC_W-1:0] ring [NSTG];
  logic signed [ACC_W-1:0] prev_q;

  logic signed [SUM_W-1:0] cur_e, nxt_e, in_e, fb_e, res_e, sum, sat;
  logic signed [5:0]       lvl_off;

  always_comb begin
    cur_e   = {{(SUM_W-ACC_W){ring[0][ACC_W-1]}}, ring[0]};
    nxt_e   = {{(SUM_W-ACC_W){ring[1][ACC_W-1]}}, ring[1]};
    if (phase == '0)
      in_e = {{(SUM_W-IN_W){x_in[IN_W-1]}}, x_in};
    else
      in_e = {{(SUM_W-ACC_W){prev_q[ACC_W-1]}}, prev_q};
    lvl_off = $signed({2'b00, lvl}) - 6'sd4;
    fb_e    = {{(SUM_W-6){lvl_off[5]}}, lvl_off} <<< FB_SH;
    if (phase == PH_W'(1))
      res_e = nxt_e >>> RES1_SH;
    else if (phase == PH_W'(3))
      res_e = nxt_e >>> RES2_SH;
    else
      res_e = '0;
    sum = cur_e + in_e - fb_e - res_e;
    if (sum > LIM_HI)
      sat = LIM_HI;
    else if (sum < LIM_LO)
      sat = LIM_LO;
    else
      sat = sum;
  end

  assign acc_new = sat[ACC_W-1:0];

  logic sat_unused_bits;
  assign sat_unused_bits = ^sat[SUM_W-1:ACC_W];

  // Ring: every cycle each entry moves one place toward the head,
  // the freshly computed stage enters at the tail.
  for (genvar g = 0; g < NSTG; g++) begin : g_ring
    if (g == NSTG - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) ring[g] <= '0;
        else     ring[g] <= acc_new;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) ring[g] <= '0;
        else     ring[g] <= ring[g+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= acc_new;
  end
endmodule

// File: rtl/sdm_xs_dither.sv
module sdm_xs_dither #(
  parameter int          DITH_W = 11,
  parameter logic [63:0] SEED_A = 64'h9E37_79B9_7F4A_7C15,
  parameter logic [63:0] SEED_B = 64'hD1B5_4A32_D192_ED03
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  output logic signed [DITH_W-1:0] dith
);
  logic [63:0] wa, wb, sum, t;

  assign sum  = wa + wb;
  assign dith = sum[63 -: DITH_W];
  assign t    = wa ^ (wa << 23);

  logic sum_unused_bits;
  assign sum_unused_bits = ^sum[63-DITH_W:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wa <= SEED_A;
      wb <= SEED_B;
    end else if (step) begin
      wa <= wb;
      wb <= t ^ wb ^ (t >> 18) ^ (wb >> 5);
    end
  end
endmodule

// File: rtl/sdm_quant.sv
module sdm_quant
  import sdm_pkg::*;
#(
  parameter int ACC_W  = 22,
  parameter int DITH_W = 11,
  parameter int FB_SH  = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic signed [ACC_W-1:0]  acc,
  input  logic signed [DITH_W-1:0] dith,
  output logic [LVL_W-1:0]         level,
  output logic [SLOTS-1:0]         pattern,
  output logic                     valid
);
  localparam int V_W = ACC_W + 2;
  localparam logic signed [V_W-1:0] HALF = V_W'(1) << (FB_SH - 1);

  logic signed [V_W-1:0] v, r, q;
  logic [LVL_W-1:0]      lvl_n;
  logic [SLOTS-1:0]      pat_n;

  always_comb begin
    v = {{(V_W-ACC_W){acc[ACC_W-1]}}, acc}
      + {{(V_W-DITH_W){dith[DITH_W-1]}}, dith};
    r = (v + HALF) >>> FB_SH;
    q = r + V_W'(MID_LVL);
    if (q < 0)
      lvl_n = '0;
    else if (q > V_W'(MAX_LVL))
      lvl_n = LVL_W'(MAX_LVL);
    else
      lvl_n = q[LVL_W-1:0];
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign pat_n[i] = (lvl_n > LVL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= LVL_W'(MID_LVL);
      pattern <= SLOTS'((1 << MID_LVL) - 1);
      valid   <= 1'b0;
    end else begin
      valid <= fire;
      if (fire) begin
        level   <= lvl_n;
        pattern <= pat_n;
      end
    end
  end
endmodule

// File: rtl/sdm_serial_shaper.sv
module sdm_serial_shaper
  import sdm_pkg::*;
#(
  parameter int          IN_W     = 16,
  parameter int          ACC_W    = 22,
  parameter int          FB_SH    = 13,
  parameter int          CLAMP_SH = 19,
  parameter int          RES1_SH  = 6,
  parameter int          RES2_SH  = 4,
  parameter int          DITH_W   = 11,
  parameter logic [63:0] SEED_A   = 64'h9E37_79B9_7F4A_7C15,
  parameter logic [63:0] SEED_B   = 64'hD1B5_4A32_D192_ED03
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [IN_W-1:0] in_sample,
  output logic                   in_take,
  output logic                   out_valid,
  output logic [LVL_W-1:0]       out_level,
  output logic [SLOTS-1:0]       out_pattern
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NSTG - 1);

  // Two-flop reset synchronizer, power-up value asserted.
  logic rst_meta = 1'b1;
  logic rst_s    = 1'b1;
  always_ff @(posedge clk) begin
    rst_meta <= rst;
    rst_s    <= rst_meta;
  end

  logic [PH_W-1:0] phase;
  logic            fire;

  always_ff @(posedge clk) begin
    if (rst_s)                phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                      phase <= phase + PH_W'(1);
  end

  assign fire    = !rst_s && (phase == LAST_PH);
  assign in_take = !rst_s && (phase == '0);

  logic signed [ACC_W-1:0]  acc_new;
  logic signed [DITH_W-1:0] dith;

  sdm_acc_ring #(
    .IN_W(IN_W), .ACC_W(ACC_W), .FB_SH(FB_SH), .CLAMP_SH(CLAMP_SH),
    .RES1_SH(RES1_SH), .RES2_SH(RES2_SH)
  ) u_ring (
    .clk(clk), .rst(rst_s), .phase(phase), .x_in(in_sample),
    .lvl(out_level), .acc_new(acc_new)
  );

  sdm_xs_dither #(.DITH_W(DITH_W), .SEED_A(SEED_A), .SEED_B(SEED_B)) u_dith (
    .clk(clk), .rst(rst_s), .step(fire), .dith(dith)
  );

  sdm_quant #(.ACC_W(ACC_W), .DITH_W(DITH_W), .FB_SH(FB_SH)) u_quant (
    .clk(clk), .rst(rst_s), .fire(fire), .acc(acc_new), .dith(dith),
    .level(out_level), .pattern(out_pattern), .valid(out_valid)
  );
endmodule

// File: rtl/sdm_shaper_chk.sv
module sdm_shaper_chk #(
  parameter int ACC_W    = 22,
  parameter int CLAMP_SH = 19
) (
  input logic                    clk,
  input logic                    rst_s,
  input logic                    in_take,
  input logic                    out_valid,
  input logic [3:0]              out_level,
  input logic [7:0]              out_pattern,
  input logic signed [ACC_W-1:0] acc_new
);
  localparam logic signed [ACC_W-1:0] HI =
    {{(ACC_W-CLAMP_SH){1'b0}}, {CLAMP_SH{1'b1}}};
  localparam logic signed [ACC_W-1:0] LO = ~HI;

  logic [2:0] gap;
  logic       seen;
  always_ff @(posedge clk) begin
    if (rst_s) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (out_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 3'd7) begin
      gap <= gap + 3'd1;
    end
  end

  assert_reset_level_R1: assert property (@(posedge clk) disable iff (rst_s)
    $fell(rst_s) |-> (out_level == 4'd4 && !out_valid));

  assert_valid_spacing_R2: assert property (@(posedge clk) disable iff (rst_s)
    (out_valid && seen) |-> gap == 3'd4);

  assert_valid_with_take_R2: assert property (@(posedge clk) disable iff (rst_s)
    out_valid |-> in_take);

  assert_stage_clamped_R5: assert property (@(posedge clk) disable iff (rst_s)
    (acc_new <= HI) && (acc_new >= LO));

  assert_level_range_R6: assert property (@(posedge clk) disable iff (rst_s)
    out_level <= 4'd8);

  assert_pattern_thermo_R6: assert property (@(posedge clk) disable iff (rst_s)
    ($countones(out_pattern) == int'(out_level))
    && ((out_pattern & (out_pattern + 8'd1)) == 8'd0));

  assert_level_hold_R9: assert property (@(posedge clk) disable iff (rst_s)
    !out_valid |-> ($stable(out_level) && $stable(out_pattern)));
endmodule

bind sdm_serial_shaper sdm_shaper_chk #(.ACC_W(ACC_W), .CLAMP_SH(CLAMP_SH)) u_chk (
  .clk(clk), .rst_s(rst_s), .in_take(in_take), .out_valid(out_valid),
  .out_level(out_level), .out_pattern(out_pattern), .acc_new(acc_new)
);

// File: tb/test_sdm_serial_shaper.sv
`timescale 1ns/100ps
module test_sdm_serial_shaper;
  localparam longint STEP = 8192;      // 2^FB_SH
  localparam longint LIM  = 524288;    // 2^CLAMP_SH
  localparam int     GROUPS = 300;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [15:0] in_sample = '0;
  logic              in_take, out_valid;
  logic [3:0]        out_level;
  logic [7:0]        out_pattern;

  always #2.5 clk = ~clk;

  sdm_serial_shaper i_sdm_serial_shaper (
    .clk(clk), .rst(rst), .in_sample(in_sample), .in_take(in_take),
    .out_valid(out_valid), .out_level(out_level), .out_pattern(out_pattern)
  );

  int vecs = 0, errs = 0;
  bit done = 0;

  longint      m_s [5];
  int          m_lvl, exp_lvl;
  bit          pend;
  logic [63:0] m_a, m_b;
  int          cyc, last_take;

  task automatic chk(input string tag, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    foreach (m_s[i]) m_s[i] = 0;
    m_lvl = 4; exp_lvl = 4; pend = 0;
    m_a = 64'h9E37_79B9_7F4A_7C15;
    m_b = 64'hD1B5_4A32_D192_ED03;
    last_take = -1;
  endtask

  function automatic longint sat(input longint v);
    if (v > LIM - 1) return LIM - 1;
    if (v < -LIM)    return -LIM;
    return v;
  endfunction

  // Unserialized loop: R3 order, R4 resonators, R5 clamp, R6 quantizer, R7 dither.
  task automatic model_step(input longint x);
    longint f, dv, v, q;
    logic [63:0] sm, t;
    f = longint'(m_lvl - 4) * STEP;
    m_s[0] = sat(m_s[0] + x - f);
    m_s[1] = sat(m_s[1] + m_s[0] - f - (m_s[2] >>> 6));
    m_s[2] = sat(m_s[2] + m_s[1] - f);
    m_s[3] = sat(m_s[3] + m_s[2] - f - (m_s[4] >>> 4));
    m_s[4] = sat(m_s[4] + m_s[3] - f);
    sm = m_a + m_b;
    dv = longint'($signed(sm[63:53]));
    t  = m_a ^ (m_a << 23);
    m_a = m_b;
    m_b = t ^ m_b ^ (t >> 18) ^ (m_b >> 5);
    v = m_s[4] + dv;
    q = ((v + STEP / 2) >>> 13) + 4;
    if (q < 0) q = 0;
    if (q > 8) q = 8;
    m_lvl = int'(q);
  endtask

  function automatic longint gen(input int pat, input int k);
    int ph;
    case (pat)
      0: return 0;
      1: return 3000;
      2: return -12000;
      3: begin
           ph = k % 64;
           return (ph < 32) ? -20000 + ph * 1250 : 20000 - (ph - 32) * 1250;
         end
      4: return 32767;             // overload drives stages into the clamp
      5: return -32768;
      default: return (k % 2 == 0) ? 30000 : -30000;
    endcase
  endfunction

  // One negedge-aligned step: compare, then feed when a sample is taken.
  task automatic tick(input int pat, input int k);
    chk("R2 out_valid", longint'(out_valid), longint'(in_take && pend));
    if (in_take && pend) begin
      exp_lvl = m_lvl;
      pend = 0;
    end
    chk("R3 R4 R5 R6 R7 R9 out_level", longint'(out_level), longint'(exp_lvl));
    chk("R6 R9 out_pattern", longint'(out_pattern), longint'((1 << exp_lvl) - 1));
    if (in_take) begin
      if (last_take >= 0) chk("R2 take period", longint'(cyc - last_take), 5);
      last_take = cyc;
      in_sample = 16'(gen(pat, k));
      model_step(longint'(in_sample));
      pend = 1;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic release_reset();
    model_reset();
    rst = 1'b0;
    @(negedge clk); cyc++;
    chk("R8 take after one edge", longint'(in_take), 0);
    @(negedge clk); cyc++;
    chk("R8 take after two edges", longint'(in_take), 1);
  endtask

  initial begin
    cyc = 0;
    model_reset();
    repeat (4) @(negedge clk);
    chk("R1 reset level", longint'(out_level), 4);
    chk("R1 reset pattern", longint'(out_pattern), 15);
    chk("R1 reset valid", longint'(out_valid), 0);
    chk("R1 reset take", longint'(in_take), 0);
    release_reset();
    for (int p = 0; p < 7; p++) begin
      for (int c = 0; c < GROUPS * 5; c++) tick(p, c / 5);
      if (p == 4) begin
        // R1: reset during overload, from clamped states
        rst = 1'b1;
        repeat (3) begin @(negedge clk); cyc++; end
        chk("R1 mid reset level", longint'(out_level), 4);
        chk("R1 mid reset pattern", longint'(out_pattern), 15);
        chk("R1 mid reset valid", longint'(out_valid), 0);
        release_reset();
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule